// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it turns the UART's NRZ serial output into return-to-zero-inverted pulses. A zero bit produces one short pulse and a one bit produces none, so every character opens with a pulse for its start bit. On the receive side it takes the transceiver's output, which is active low by default, and turns each accepted pulse back into a zero bit on an NRZ line that feeds the UART receiver. The codec does not look at frame contents. It relies on a tick at 16 times the bit rate, and the UART transmitter changes its output only on such a tick.

The transmit pulse nominally covers ticks 7 to 9 of the 16 ticks of a zero bit. That is 3/16 of the bit, centred. The leading and trailing edges can each be moved earlier or later by a programmable number of clock cycles. The block measures the tick spacing in clock cycles and places the edges by counting cycles from the start of the bit. On receive, an optional filter discards pulses whose width is not greater than a programmed number of cycles. Either line can be inverted. With the codec disabled, both paths pass their inputs straight through.

Top module: `ir_sir_codec`

## Requirements
- R1: When `sir_en` is 0, `ir_txd` equals `uart_txd` and `uart_rxd` equals `ir_rxd` combinationally, with no inversion applied.
- R2: When enabled with no shifts, a zero bit drives `ir_txd` high (with `tx_inv` = 0) for the cycles 7P to 10P-1 of the bit, and a one bit leaves it low. Here P is the tick spacing in clock cycles, and cycle 0 is the edge that captures a new `uart_txd` value or the 16th tick of the previous bit. Consecutive zero bits each get their own pulse.
- R3: `lead_late` = 1 moves the leading edge `lead_shift` cycles later. `lead_late` = 0 moves it that many cycles earlier, and it is clamped at cycle 0 of the bit.
- R4: `trail_late` and `trail_shift` move the trailing edge from 10P in the same way. A pulse never extends past the end of its own bit. If the leading edge is not before the trailing edge, the bit produces no pulse.
- R5: `tx_inv` = 1 inverts `ir_txd` in codec mode, so the line idles high and pulses low.
- R6: With `rx_inv` = 0 a low level on `ir_rxd` is a pulse, and with `rx_inv` = 1 a high level is a pulse. With the filter off, `uart_rxd` goes low on the third clock edge after the line turns active. It returns high after the 16th tick that follows the edge at which the pulse was detected.
- R7: With `rx_filt_en` = 1, a pulse is accepted only if it stays active for more than `rx_filt_thr` cycles. `uart_rxd` then goes low `rx_filt_thr` cycles later than in R6 and is released as in R6. A pulse that is too short leaves `uart_rxd` high throughout.
- R8: If a new pulse is detected on the same edge as the 16th tick of the current hold, the new pulse wins. `uart_rxd` stays low without a gap and a fresh 16-tick hold starts.
- R9: After reset, with codec mode on and no inversion, `ir_txd` is 0 and `uart_rxd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sir_en | input | 1 | 1 selects infrared coding, 0 passes signals through |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| uart_txd | input | 1 | NRZ transmit bit from the UART |
| ir_txd | output | 1 | Line to the infrared emitter |
| ir_rxd | input | 1 | Raw line from the infrared receiver |
| uart_rxd | output | 1 | Recovered NRZ line to the UART receiver |
| tx_inv | input | 1 | Invert `ir_txd` in codec mode |
| rx_inv | input | 1 | Invert the sense of `ir_rxd` |
| lead_shift | input | SHIFT_W | Leading-edge move in clock cycles |
| lead_late | input | 1 | 1 moves the leading edge later, 0 earlier |
| trail_shift | input | SHIFT_W | Trailing-edge move in clock cycles |
| trail_late | input | 1 | 1 moves the trailing edge later, 0 earlier |
| rx_filt_en | input | 1 | Enable the minimum-width receive filter |
| rx_filt_thr | input | SHIFT_W | Width a pulse must exceed, in cycles |

## Verification
The events most likely to collide are both on the receive side: the release of a 16-tick hold and the detection of the next pulse's leading edge. Two back-to-back zero bits are provoked so that the second pulse is detected on exactly the edge that carries the 16th tick of the first hold. The bench then requires `uart_rxd` to stay low with no gap until 16 ticks after the second pulse. On the transmit side, a new `uart_txd` value always arrives on a tick, so a bit restart and a tick fall together on every bit. This is judged by checking each consecutive zero bit's pulse window cycle by cycle, including when the window is clamped at either end of the bit.

// File: rtl/sir_pkg.sv
package sir_pkg;
    // Oversampling ticks in one bit time and the nominal pulse window in ticks.
    localparam int TICKS_PER_BIT = 16;
    localparam int LEAD_TICK     = 7;
    localparam int TRAIL_TICK    = 10;

    typedef enum logic {
        EDGE_EARLY = 1'b0,
        EDGE_LATE  = 1'b1
    } edge_dir_e;
endpackage

// File: rtl/sir_tick_meter.sv
module sir_tick_meter #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [PER_W-1:0] per
);
    localparam logic [PER_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
    } meter_t;

    meter_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (tick) begin
            m_d.per = (m_q.cnt == CNT_MAX) ? CNT_MAX : m_q.cnt + 1'b1;
            m_d.cnt = '0;
        end else if (m_q.cnt != CNT_MAX) begin
            m_d.cnt = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign per = m_q.per;

    // A measured spacing is never zero once a tick has been seen (R2 timing base).
    assert_period_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (per != '0));
endmodule

// File: rtl/sir_tx_shaper.sv
module sir_tx_shaper #(
    parameter int PER_W   = 16,
    parameter int SHIFT_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               txd,
    input  logic [PER_W-1:0]   per,
    input  logic [SHIFT_W-1:0] lead_mag,
    input  logic               lead_late,
    input  logic [SHIFT_W-1:0] trail_mag,
    input  logic               trail_late,
    output logic               pulse
);
    import sir_pkg::*;

    localparam int PH_W   = $clog2(TICKS_PER_BIT);
    localparam int BASE_W = PER_W + 4;
    localparam int POS_W  = ((BASE_W > SHIFT_W) ? BASE_W : SHIFT_W) + 1;
    localparam logic [PH_W-1:0]  PH_LAST = PH_W'(TICKS_PER_BIT - 1);
    localparam logic [POS_W-1:0] CYC_MAX = '1;

    typedef struct packed {
        logic             bit_v;
        logic [PH_W-1:0]  phase;
        logic [POS_W-1:0] cyc;
        logic             pulse;
    } tx_t;

    tx_t s_d, s_q;

    logic [POS_W-1:0] per_x, lead_base, trail_base, lead_pos, trail_pos;
    logic             restart;

    function automatic logic [POS_W-1:0] move_edge(
        input logic [POS_W-1:0] base,
        input logic [POS_W-1:0] mag,
        input logic             late
    );
        if (late == EDGE_LATE) return base + mag;
        return (mag > base) ? '0 : base - mag;
    endfunction

    always_comb begin
        per_x      = POS_W'(per);
        lead_base  = POS_W'(per_x * POS_W'(LEAD_TICK));
        trail_base = POS_W'(per_x * POS_W'(TRAIL_TICK));
        lead_pos   = move_edge(lead_base, POS_W'(lead_mag), lead_late);
        trail_pos  = move_edge(trail_base, POS_W'(trail_mag), trail_late);
    end

    always_comb begin
        s_d     = s_q;
        restart = (txd != s_q.bit_v) || (tick && (s_q.phase == PH_LAST));
        if (restart) begin
            s_d.bit_v = txd;
            s_d.phase = '0;
            s_d.cyc   = '0;
        end else begin
            if (tick) s_d.phase = s_q.phase + 1'b1;
            if (s_q.cyc != CYC_MAX) s_d.cyc = s_q.cyc + 1'b1;
        end
        s_d.pulse = en && !s_d.bit_v && (s_d.cyc >= lead_pos) && (s_d.cyc < trail_pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.bit_v <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;

    // A pulse is only ever emitted inside a zero bit.
    assert_pulse_only_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pulse |-> !s_q.bit_v);

    // Every new data value restarts the in-bit cycle count (pulse stays in its own bit, R4).
    assert_bit_restarts_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.bit_v != $past(s_q.bit_v)) |-> (s_q.cyc == '0));
endmodule

// File: rtl/sir_sync.sv
module sir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r_d, r_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb r_d = d;
        end else begin : g_chain
            always_comb r_d = {r_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign q = r_q[STAGES-1];
endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch #(
    parameter int SHIFT_W = 15,
    parameter int TICKS   = sir_pkg::TICKS_PER_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               act,
    input  logic               tick,
    input  logic               filt_en,
    input  logic [SHIFT_W-1:0] thr,
    output logic               nrz
);
    localparam int WID_W = SHIFT_W + 1;
    localparam int TK_W  = $clog2(TICKS + 1);
    localparam logic [WID_W-1:0] WID_MAX = '1;
    localparam logic [TK_W-1:0]  TK_LAST = TK_W'(TICKS);

    typedef struct packed {
        logic             prev;
        logic             hold;
        logic             acc;
        logic [WID_W-1:0] wid;
        logic [TK_W-1:0]  tk;
    } rx_t;

    rx_t s_d, s_q;

    logic             edge_w;
    logic [WID_W-1:0] thr_x, wid_inc;

    always_comb begin
        thr_x   = WID_W'(thr);
        edge_w  = act && !s_q.prev;
        wid_inc = (s_q.wid == WID_MAX) ? s_q.wid : s_q.wid + 1'b1;
        s_d      = s_q;
        s_d.prev = act;
        if (!en) begin
            s_d      = '0;
            s_d.prev = act;
        end else if (edge_w) begin
            // A fresh leading edge takes priority over any release this cycle.
            s_d.hold = 1'b1;
            s_d.tk   = '0;
            s_d.wid  = WID_W'(1);
            s_d.acc  = !filt_en || (WID_W'(1) > thr_x);
        end else if (s_q.hold) begin
            if (act) begin
                s_d.wid = wid_inc;
                if (!filt_en || (wid_inc > thr_x)) s_d.acc = 1'b1;
            end else if (!s_q.acc) begin
                s_d.hold = 1'b0;
            end
            if (tick) begin
                s_d.tk = s_q.tk + 1'b1;
                if (s_d.tk == TK_LAST) begin
                    s_d.hold = 1'b0;
                    s_d.acc  = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nrz = !(s_q.hold && s_q.acc);

    // The hold never outlives one bit time of ticks.
    assert_hold_within_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hold |-> (s_q.tk < TK_LAST));

    // With the filter on, acceptance only follows a width above the threshold.
    assert_accept_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.acc) && $past(filt_en)) |-> (s_q.wid > $past(thr_x)));

    // A leading edge during a hold keeps the hold alive.
    assert_restart_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && edge_w && s_q.hold) |=> s_q.hold);
endmodule

// File: rtl/ir_sir_codec.sv
module ir_sir_codec #(
    parameter int PER_W       = 16,
    parameter int SHIFT_W     = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sir_en,
    input  logic               tick16,
    input  logic               uart_txd,
    output logic               ir_txd,
    input  logic               ir_rxd,
    output logic               uart_rxd,
    input  logic               tx_inv,
    input  logic               rx_inv,
    input  logic [SHIFT_W-1:0] lead_shift,
    input  logic               lead_late,
    input  logic [SHIFT_W-1:0] trail_shift,
    input  logic               trail_late,
    input  logic               rx_filt_en,
    input  logic [SHIFT_W-1:0] rx_filt_thr
);
    logic [PER_W-1:0] tick_per;
    logic             tx_pulse;
    logic             rx_act_raw, rx_act;
    logic             rx_nrz;

    sir_tick_meter #(.PER_W(PER_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .per   (tick_per)
    );

    sir_tx_shaper #(.PER_W(PER_W), .SHIFT_W(SHIFT_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (sir_en),
        .tick       (tick16),
        .txd        (uart_txd),
        .per        (tick_per),
        .lead_mag   (lead_shift),
        .lead_late  (lead_late),
        .trail_mag  (trail_shift),
        .trail_late (trail_late),
        .pulse      (tx_pulse)
    );

    // Active-pulse level: low by default, high when the receive sense is inverted.
    assign rx_act_raw = !(ir_rxd ^ rx_inv);

    sir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_act_raw),
        .q     (rx_act)
    );

    sir_rx_stretch #(.SHIFT_W(SHIFT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sir_en),
        .act     (rx_act),
        .tick    (tick16),
        .filt_en (rx_filt_en),
        .thr     (rx_filt_thr),
        .nrz     (rx_nrz)
    );

    assign ir_txd   = sir_en ? (tx_pulse ^ tx_inv) : uart_txd;
    assign uart_rxd = sir_en ? rx_nrz : ir_rxd;

    // Outside codec mode the coder keeps its pulse register quiet (R1).
    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sir_en |=> (!sir_en -> !tx_pulse));
endmodule

// File: tb/sim_ir_sir_codec.sv
module sim_ir_sir_codec;
    localparam int CLK_PERIOD = 10;
    localparam int SHIFT_W    = 15;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               sir_en;
    logic               tick16;
    logic               uart_txd;
    logic               ir_txd;
    logic               ir_rxd;
    logic               uart_rxd;
    logic               tx_inv;
    logic               rx_inv;
    logic [SHIFT_W-1:0] lead_shift;
    logic               lead_late;
    logic [SHIFT_W-1:0] trail_shift;
    logic               trail_late;
    logic               rx_filt_en;
    logic [SHIFT_W-1:0] rx_filt_thr;

    int n_tests = 0;
    int n_fail  = 0;

    ir_sir_codec #(.PER_W(16), .SHIFT_W(SHIFT_W), .SYNC_STAGES(2)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sir_en      (sir_en),
        .tick16      (tick16),
        .uart_txd    (uart_txd),
        .ir_txd      (ir_txd),
        .ir_rxd      (ir_rxd),
        .uart_rxd    (uart_rxd),
        .tx_inv      (tx_inv),
        .rx_inv      (rx_inv),
        .lead_shift  (lead_shift),
        .lead_late   (lead_late),
        .trail_shift (trail_shift),
        .trail_late  (trail_late),
        .rx_filt_en  (rx_filt_en),
        .rx_filt_thr (rx_filt_thr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_bit(input string req, input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // R9: reset state
    task automatic test_reset();
        rst_n = 1'b0; sir_en = 1'b1; tick16 = 1'b0; uart_txd = 1'b1; ir_rxd = 1'b1;
        tx_inv = 1'b0; rx_inv = 1'b0; lead_shift = '0; lead_late = 1'b0;
        trail_shift = '0; trail_late = 1'b0; rx_filt_en = 1'b0; rx_filt_thr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_bit("R9", "ir_txd after reset", ir_txd, 1'b0);
        check_bit("R9", "uart_rxd after reset", uart_rxd, 1'b1);
    endtask

    // R1: pass-through when codec mode is off
    task automatic test_passthrough();
        sir_en = 1'b0; tx_inv = 1'b1; rx_inv = 1'b1;
        uart_txd = 1'b0; ir_rxd = 1'b0;
        #1;
        check_bit("R1", "ir_txd follows uart_txd=0", ir_txd, 1'b0);
        check_bit("R1", "uart_rxd follows ir_rxd=0", uart_rxd, 1'b0);
        uart_txd = 1'b1; ir_rxd = 1'b1;
        #1;
        check_bit("R1", "ir_txd follows uart_txd=1", ir_txd, 1'b1);
        check_bit("R1", "uart_rxd follows ir_rxd=1", uart_rxd, 1'b1);
        @(negedge clk);
        tx_inv = 1'b0; rx_inv = 1'b0; sir_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Transmit: one idle bit, then nb bits (bits[0] first, must be 0), checked each cycle.
    task automatic tx_case(input string req, input int t, input logic inv,
                           input int lm, input logic ll, input int tm, input logic tl,
                           input logic [7:0] bits, input int nb);
        int   lead, trail, bad_b, bad_k;
        logic exp_v, bad_got, bad_exp, bad;
        lead  = ll ? 7*t + lm : ((lm > 7*t) ? 0 : 7*t - lm);
        trail = tl ? 10*t + tm : ((tm > 10*t) ? 0 : 10*t - tm);
        bad = 1'b0; bad_b = 0; bad_k = 0; bad_got = 1'b0; bad_exp = 1'b0;
        tx_inv = inv; lead_shift = SHIFT_W'(lm); lead_late = ll;
        trail_shift = SHIFT_W'(tm); trail_late = tl;
        @(negedge clk);
        uart_txd = 1'b1; tick16 = 1'b1;
        for (int b = 0; b <= nb; b++) begin
            for (int k = 0; k < 16*t; k++) begin
                @(negedge clk);
                if (b > 0) begin
                    exp_v = inv ^ (!bits[b-1] && (k >= lead) && (k < trail));
                    if ((ir_txd !== exp_v) && !bad) begin
                        bad = 1'b1; bad_b = b; bad_k = k; bad_got = ir_txd; bad_exp = exp_v;
                    end
                end
                if (k == 16*t - 1) begin
                    uart_txd = (b < nb) ? bits[b] : 1'b1;
                    tick16 = 1'b1;
                end else begin
                    tick16 = ((k + 1) % t == 0);
                end
            end
        end
        tick16 = 1'b0;
        n_tests++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s tx bit %0d cycle %0d: got ir_txd=%b expected %b", req, bad_b, bad_k, bad_got, bad_exp);
        end
        tx_inv = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Receive: pulses at offsets [0,w1) and [s2,s2+w2), ticks every 4 cycles from offset 0.
    // uart_rxd must be low exactly for offsets lo..hi (sampled after the edge of that offset).
    task automatic rx_case(input string req, input logic filt, input int thr, input logic inv,
                           input int w1, input int s2, input int w2, input int lo, input int hi);
        logic exp_v, bad, bad_got, bad_exp, on;
        int   bad_k;
        bad = 1'b0; bad_k = 0; bad_got = 1'b0; bad_exp = 1'b0;
        rx_filt_en = filt; rx_filt_thr = SHIFT_W'(thr);
        rx_inv = inv; ir_rxd = !inv; tick16 = 1'b0;
        repeat (8) @(negedge clk);
        for (int off = 0; off < 160; off++) begin
            on = (off < w1) || ((s2 >= 0) && (off >= s2) && (off < s2 + w2));
            ir_rxd = on ? inv : !inv;
            tick16 = (off % 4 == 0);
            @(negedge clk);
            exp_v = !((off >= lo) && (off <= hi));
            if ((uart_rxd !== exp_v) && !bad) begin
                bad = 1'b1; bad_k = off; bad_got = uart_rxd; bad_exp = exp_v;
            end
        end
        ir_rxd = !inv; tick16 = 1'b0;
        n_tests++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s rx offset %0d: got uart_rxd=%b expected %b", req, bad_k, bad_got, bad_exp);
        end
        repeat (6) @(negedge clk);
        rx_inv = 1'b0; ir_rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset();                                            // R9
        test_passthrough();                                      // R1
        // R2: nominal window 28..39 with tick spacing 4, bits 0,1,0,0,1
        tx_case("R2", 4, 1'b0, 0, 1'b0, 0, 1'b0, 8'b0001_0010, 5);
        // R3 R4: leading edge 5 earlier, trailing edge 3 later -> 23..42
        tx_case("R3", 4, 1'b0, 5, 1'b0, 3, 1'b1, 8'b0000_0010, 3);
        // R3 R4: leading edge 4 later, trailing edge 2 earlier -> 32..37
        tx_case("R4", 4, 1'b0, 4, 1'b1, 2, 1'b0, 8'b0000_0100, 3);
        // R4: trailing edge beyond bit end is cut at 63, two zero bits back to back
        tx_case("R4", 4, 1'b0, 0, 1'b0, 40, 1'b1, 8'b0000_0100, 3);
        // R3: early move larger than the base clamps at cycle 0 -> 0..39
        tx_case("R3", 4, 1'b0, 100, 1'b0, 0, 1'b0, 8'b0000_0100, 3);
        // R4: leading edge 48 not before trailing edge 40 -> no pulse
        tx_case("R4", 4, 1'b0, 20, 1'b1, 0, 1'b0, 8'b0000_0100, 3);
        // R5: inverted transmit line
        tx_case("R5", 4, 1'b1, 0, 1'b0, 0, 1'b0, 8'b0000_1010, 4);
        // R2: tick spacing 8 -> 56..79
        tx_case("R2", 8, 1'b0, 0, 1'b0, 0, 1'b0, 8'b0000_0100, 3);
        // R6: unfiltered, low on offsets 2..63
        rx_case("R6", 1'b0, 0, 1'b0, 6, -1, 0, 2, 63);
        // R6: inverted receive sense
        rx_case("R6", 1'b0, 0, 1'b1, 3, -1, 0, 2, 63);
        // R7: width 6 > 5 accepted, low from offset 7
        rx_case("R7", 1'b1, 5, 1'b0, 6, -1, 0, 7, 63);
        // R7: width 6 not > 6 rejected, never low
        rx_case("R7", 1'b1, 6, 1'b0, 6, -1, 0, 1, 0);
        // R8: second pulse detected on the 16th tick edge, low 2..127 without a gap
        rx_case("R8", 1'b0, 0, 1'b0, 6, 62, 6, 2, 127);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule